// File: doc/BRIEF.md
# Cascaded Biquad Filter Engine

This block runs four parallel audio record channels through a pool of twelve second-order recursive filter sections. A configuration register sets how many sections run in series on each channel: zero, one, two or three. Section s (counted from 0) always serves channel s mod 4. Channel c therefore takes sections c, c+4 and c+8 in that order, and only as many of them as the configuration allows.

One multiply-accumulate unit is time-shared across all active sections. A frame is accepted with a single strobe. The engine then visits the channels in order, and for each channel the active sections in ascending order. It fetches the five coefficients of every section from an external coefficient store through a synchronous read port. When the last section is finished it presents all four results together with a one-cycle done strobe. Each section keeps its own delay history, and a change of configuration clears all of that history.

Top module: `biquad_cascade_engine`

## Requirements
- R1: After reset `done` is 0, `coef_rd` is 0, `sample_out` is all zeros, and the configuration holds code 2'b10, so each channel uses two sections until the configuration is written.
- R2: Configuration code k (2'b00 to 2'b11) cascades k sections per channel. Section s serves channel s mod 4, in ascending s. Sections numbered 4k and above are never read during a frame.
- R3: With code 2'b00 each `sample_out` lane equals the matching `sample_in` lane, and `done` rises in the cycle after the frame is accepted.
- R4: A section computes floor((b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2) / 2^30). Coefficients are signed 32-bit with 30 fractional bits and coefficient index 0..4 selects b0, b1, b2, a1, a2. x1 and x2 are the section's previous two inputs and y1 and y2 its previous two outputs.
- R5: A section result outside the signed 16-bit range saturates to 32767 or −32768.
- R6: With b0 = 2^30 and the other four coefficients 0 on every section, each output equals its input for any code.
- R7: A section's history advances once per frame in which it is active. Reset clears it, and so does a configuration write that changes the code.
- R8: Each read is a `coef_rd` pulse with `coef_sec` and `coef_idx`, and its data must be on `coef_data` in the next cycle. A section reads indices 0 to 4 in consecutive cycles, starting in the cycle after the frame is accepted. A frame reads exactly 20·k words.
- R9: Each section takes six cycles. `done` rises 24·k + 1 cycles after the cycle in which `frame_valid` was accepted, for a single cycle.
- R10: While a frame is in progress, `frame_valid` and `cfg_we` are ignored. No second frame starts and the code does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Loads `cfg_in` into the configuration while idle |
| cfg_in | input | 2 | Sections-per-channel code |
| frame_valid | input | 1 | Accepts `sample_in` as a new frame while idle |
| sample_in | input | 64 | Four signed 16-bit samples, channel 0 in bits 15:0 |
| coef_rd | output | 1 | Coefficient read request |
| coef_sec | output | 4 | Section index of the read |
| coef_idx | output | 3 | Coefficient index of the read (0..4) |
| coef_data | input | 32 | Coefficient word, one cycle after the request |
| sample_out | output | 64 | Four filtered signed 16-bit samples, channel 0 in bits 15:0 |
| done | output | 1 | One-cycle pulse when `sample_out` holds a new frame |

## Verification
A wrong sequencer state shows up at once on the coefficient port. An out-of-order index, a read of an inactive section or a wrong read count is visible within the same frame. A fault in the shared accumulator or in the saturation logic changes `sample_out` at the next `done`. A history entry that is not cleared, not advanced, or written to the wrong section only changes results one or two frames later. For that reason, frames are run back to back per configuration and compared with an exact integer model of every section's history.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    localparam int unsigned TAPS    = 5;
    localparam int unsigned STEP_W  = 3;
    localparam logic [STEP_W-1:0] STEP_WB = 3'd5;
    localparam logic [STEP_W-1:0] STEP_A1 = 3'd4;
endpackage

// File: rtl/biquad_mac.sv
module biquad_mac #(
    parameter int SAMPLE_W  = 16,
    parameter int COEF_W    = 32,
    parameter int COEF_FRAC = 30
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       first,
    input  logic                       sub,
    input  logic signed [COEF_W-1:0]   coef,
    input  logic signed [SAMPLE_W-1:0] opnd,
    output logic signed [SAMPLE_W-1:0] result
);
    localparam int PROD_W = SAMPLE_W + COEF_W;
    localparam int ACC_W  = PROD_W + 3;
    localparam logic signed [ACC_W-1:0] SMAX =
        $signed({{(ACC_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}});
    localparam logic signed [ACC_W-1:0] SMIN =
        $signed({{(ACC_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}});

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } mac_t;

    mac_t mac_d, mac_q;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  base;
    logic signed [ACC_W-1:0]  sum;
    logic signed [ACC_W-1:0]  scaled;

    always_comb begin
        prod     = opnd * coef;
        prod_ext = $signed({{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod});
        base     = first ? '0 : mac_q.acc;
        sum      = sub ? (base - prod_ext) : (base + prod_ext);
        scaled   = sum >>> COEF_FRAC;
        if (scaled > SMAX) begin
            result = SMAX[SAMPLE_W-1:0];
        end else if (scaled < SMIN) begin
            result = SMIN[SAMPLE_W-1:0];
        end else begin
            result = scaled[SAMPLE_W-1:0];
        end
        mac_d = mac_q;
        if (en) begin
            mac_d.acc = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mac_q <= '0;
        end else begin
            mac_q <= mac_d;
        end
    end
endmodule

// File: rtl/biquad_hist.sv
module biquad_hist #(
    parameter int N_SEC    = 12,
    parameter int SAMPLE_W = 16,
    parameter int SEC_W    = $clog2(N_SEC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr,
    input  logic [SEC_W-1:0]    sec,
    input  logic [SAMPLE_W-1:0] x_new,
    input  logic [SAMPLE_W-1:0] y_new,
    output logic [SAMPLE_W-1:0] x1,
    output logic [SAMPLE_W-1:0] x2,
    output logic [SAMPLE_W-1:0] y1,
    output logic [SAMPLE_W-1:0] y2
);
    typedef struct packed {
        logic [N_SEC-1:0][SAMPLE_W-1:0] x1;
        logic [N_SEC-1:0][SAMPLE_W-1:0] x2;
        logic [N_SEC-1:0][SAMPLE_W-1:0] y1;
        logic [N_SEC-1:0][SAMPLE_W-1:0] y2;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        x1 = '0;
        x2 = '0;
        y1 = '0;
        y2 = '0;
        for (int i = 0; i < N_SEC; i++) begin
            if (sec == SEC_W'(i)) begin
                x1 = h_q.x1[i];
                x2 = h_q.x2[i];
                y1 = h_q.y1[i];
                y2 = h_q.y2[i];
                if (wr) begin
                    h_d.x2[i] = h_q.x1[i];
                    h_d.x1[i] = x_new;
                    h_d.y2[i] = h_q.y1[i];
                    h_d.y1[i] = y_new;
                end
            end
        end
        if (clr) begin
            h_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end
endmodule

// File: rtl/biquad_cascade_engine.sv
module biquad_cascade_engine #(
    parameter int N_CH       = 4,
    parameter int MAX_STAGES = 3,
    parameter int SAMPLE_W   = 16,
    parameter int COEF_W     = 32,
    parameter int COEF_FRAC  = 30,
    parameter int CFG_RESET  = 2,
    parameter int N_SEC      = N_CH * MAX_STAGES,
    parameter int SEC_W      = $clog2(N_SEC),
    parameter int CFG_W      = $clog2(MAX_STAGES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [CFG_W-1:0]           cfg_in,
    input  logic                       frame_valid,
    input  logic [N_CH*SAMPLE_W-1:0]   sample_in,
    output logic                       coef_rd,
    output logic [SEC_W-1:0]           coef_sec,
    output logic [2:0]                 coef_idx,
    input  logic [COEF_W-1:0]          coef_data,
    output logic [N_CH*SAMPLE_W-1:0]   sample_out,
    output logic                       done
);
    import biquad_pkg::*;

    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int STG_W = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1;

    typedef struct packed {
        phase_e                     phase;
        logic [CFG_W-1:0]           cfg;
        logic [CH_W-1:0]            ch;
        logic [STG_W-1:0]           stg;
        logic [STEP_W-1:0]          step;
        logic [N_CH*SAMPLE_W-1:0]   xin;
        logic [SAMPLE_W-1:0]        cur_x;
        logic [N_CH*SAMPLE_W-1:0]   yout;
        logic                       done;
    } eng_t;

    eng_t st_d, st_q;

    logic [SEC_W-1:0]           sec_idx;
    logic                       last_stg;
    logic                       last_ch;
    logic [CFG_W-1:0]           eff_cfg;
    logic [CH_W-1:0]            nxt_ch;
    logic                       hist_clr;
    logic                       hist_wr;
    logic [SAMPLE_W-1:0]        hx1, hx2, hy1, hy2;
    logic                       mac_en, mac_first, mac_sub;
    logic signed [SAMPLE_W-1:0] mac_opnd;
    logic signed [SAMPLE_W-1:0] mac_y;
    logic                       run_act;
    logic [CFG_W-1:0]           cfg_act;

    // sequencing of the shared datapath
    always_comb begin
        sec_idx   = SEC_W'(int'(st_q.stg) * N_CH + int'(st_q.ch));
        last_stg  = (int'(st_q.stg) == int'(st_q.cfg) - 1);
        last_ch   = (int'(st_q.ch) == N_CH - 1);
        run_act   = (st_q.phase == PH_RUN);
        mac_en    = run_act && (st_q.step != '0);
        mac_first = (st_q.step == STEP_W'(1));
        mac_sub   = (st_q.step >= STEP_A1);
        unique case (st_q.step)
            3'd1:    mac_opnd = $signed(st_q.cur_x);
            3'd2:    mac_opnd = $signed(hx1);
            3'd3:    mac_opnd = $signed(hx2);
            3'd4:    mac_opnd = $signed(hy1);
            3'd5:    mac_opnd = $signed(hy2);
            default: mac_opnd = '0;
        endcase
    end

    // next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        hist_clr  = 1'b0;
        hist_wr   = 1'b0;
        eff_cfg   = cfg_we ? cfg_in : st_q.cfg;
        nxt_ch    = st_q.ch + 1'b1;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (cfg_we) begin
                    st_d.cfg = cfg_in;
                    hist_clr = (cfg_in != st_q.cfg);
                end
                if (frame_valid) begin
                    if (eff_cfg == '0) begin
                        st_d.yout = sample_in;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.phase = PH_RUN;
                        st_d.xin   = sample_in;
                        st_d.cur_x = sample_in[SAMPLE_W-1:0];
                        st_d.ch    = '0;
                        st_d.stg   = '0;
                        st_d.step  = '0;
                    end
                end
            end
            PH_RUN: begin
                if (st_q.step == STEP_WB) begin
                    hist_wr    = 1'b1;
                    st_d.step  = '0;
                    st_d.cur_x = mac_y;
                    if (last_stg) begin
                        st_d.yout[st_q.ch*SAMPLE_W +: SAMPLE_W] = mac_y;
                        if (last_ch) begin
                            st_d.phase = PH_IDLE;
                            st_d.done  = 1'b1;
                        end else begin
                            st_d.ch    = nxt_ch;
                            st_d.stg   = '0;
                            st_d.cur_x = st_q.xin[nxt_ch*SAMPLE_W +: SAMPLE_W];
                        end
                    end else begin
                        st_d.stg = st_q.stg + 1'b1;
                    end
                end else begin
                    st_d.step = st_q.step + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cfg <= CFG_W'(CFG_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    biquad_hist #(
        .N_SEC   (N_SEC),
        .SAMPLE_W(SAMPLE_W),
        .SEC_W   (SEC_W)
    ) u_hist (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (hist_clr),
        .wr   (hist_wr),
        .sec  (sec_idx),
        .x_new(st_q.cur_x),
        .y_new(mac_y),
        .x1   (hx1),
        .x2   (hx2),
        .y1   (hy1),
        .y2   (hy2)
    );

    biquad_mac #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .COEF_FRAC(COEF_FRAC)
    ) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mac_en),
        .first (mac_first),
        .sub   (mac_sub),
        .coef  ($signed(coef_data)),
        .opnd  (mac_opnd),
        .result(mac_y)
    );

    assign cfg_act    = st_q.cfg;
    assign coef_rd    = run_act && (st_q.step < STEP_WB);
    assign coef_sec   = sec_idx;
    assign coef_idx   = st_q.step;
    assign sample_out = st_q.yout;
    assign done       = st_q.done;
endmodule

// File: rtl/biquad_cascade_engine_chk.sv
module biquad_cascade_engine_chk #(
    parameter int N_CH     = 4,
    parameter int SAMPLE_W = 16,
    parameter int SEC_W    = 4,
    parameter int CFG_W    = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_we,
    input logic                     frame_valid,
    input logic [N_CH*SAMPLE_W-1:0] sample_in,
    input logic                     coef_rd,
    input logic [SEC_W-1:0]         coef_sec,
    input logic [2:0]               coef_idx,
    input logic [N_CH*SAMPLE_W-1:0] sample_out,
    input logic                     done,
    input logic                     run_act,
    input logic [CFG_W-1:0]         cfg_act
);
    a_r2_active_sections_only: assert property (@(posedge clk) disable iff (!rst_n)
        coef_rd |-> (coef_idx <= 3'd4) && (int'(coef_sec) < N_CH * int'(cfg_act)));

    a_r3_bypass_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_act && frame_valid && !cfg_we && cfg_act == '0)
        |=> done && (sample_out == $past(sample_in)));

    a_r8_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_act && frame_valid && !cfg_we && cfg_act != '0)
        |=> coef_rd && coef_sec == '0 && coef_idx == 3'd0);

    a_r8_index_order: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_rd && coef_idx < 3'd4)
        |=> coef_rd && (coef_idx == $past(coef_idx) + 3'd1) && $stable(coef_sec));

    a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !run_act);

    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        run_act |=> $stable(cfg_act));
endmodule

bind biquad_cascade_engine biquad_cascade_engine_chk #(
    .N_CH    (N_CH),
    .SAMPLE_W(SAMPLE_W),
    .SEC_W   (SEC_W),
    .CFG_W   (CFG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .frame_valid(frame_valid),
    .sample_in  (sample_in),
    .coef_rd    (coef_rd),
    .coef_sec   (coef_sec),
    .coef_idx   (coef_idx),
    .sample_out (sample_out),
    .done       (done),
    .run_act    (run_act),
    .cfg_act    (cfg_act)
);

// File: tb/biquad_cascade_engine_bench.sv
module biquad_cascade_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_in = 2'd0;
    logic        frame_valid = 1'b0;
    logic [63:0] sample_in = '0;
    logic        coef_rd;
    logic [3:0]  coef_sec;
    logic [2:0]  coef_idx;
    logic [31:0] coef_data = '0;
    logic [63:0] sample_out;
    logic        done;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    biquad_cascade_engine u_biquad_cascade_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_in(cfg_in),
        .frame_valid(frame_valid), .sample_in(sample_in),
        .coef_rd(coef_rd), .coef_sec(coef_sec), .coef_idx(coef_idx),
        .coef_data(coef_data), .sample_out(sample_out), .done(done)
    );

    // coefficient store and read log
    longint coef_mem [12][5];
    int     rd_count = 0;
    int     max_sec  = -1;

    always @(posedge clk) begin
        if (coef_rd) begin
            rd_count <= rd_count + 1;
            if (int'(coef_sec) > max_sec) max_sec <= int'(coef_sec);
            if (coef_sec < 4'd12 && coef_idx < 3'd5)
                coef_data <= coef_mem[coef_sec][coef_idx][31:0];
            else
                coef_data <= '0;
        end
    end

    // exact integer model
    longint hx1 [12], hx2 [12], hy1 [12], hy2 [12];
    int     mcfg = 2;

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 12; i++) begin
            hx1[i] = 0; hx2[i] = 0; hy1[i] = 0; hy2[i] = 0;
        end
    endtask

    task automatic model_frame(input longint s [4], output longint e [4]);
        for (int c = 0; c < 4; c++) begin
            longint v = s[c];
            for (int st = 0; st < mcfg; st++) begin
                int k = st * 4 + c;
                longint acc = coef_mem[k][0] * v + coef_mem[k][1] * hx1[k]
                            + coef_mem[k][2] * hx2[k] - coef_mem[k][3] * hy1[k]
                            - coef_mem[k][4] * hy2[k];
                longint y = sat16(acc >>> 30);
                hx2[k] = hx1[k]; hx1[k] = v;
                hy2[k] = hy1[k]; hy1[k] = y;
                v = y;
            end
            e[c] = v;
        end
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint lane(input logic [63:0] v, input int c);
        return longint'($signed(v[c*16 +: 16]));
    endfunction

    task automatic load_general();
        for (int n = 0; n < 12; n++) begin
            coef_mem[n][0] = 64'sd536870912 + longint'(n) * 16777216;
            coef_mem[n][1] = 64'sd268435456 - longint'(n) * 8388608;
            coef_mem[n][2] = 64'sd134217728;
            coef_mem[n][3] = -64'sd268435456;
            coef_mem[n][4] = 64'sd67108864 + longint'(n) * 4194304;
        end
    endtask

    task automatic load_pass();
        for (int n = 0; n < 12; n++) begin
            coef_mem[n][0] = 64'sd1073741824;
            for (int t = 1; t < 5; t++) coef_mem[n][t] = 0;
        end
    endtask

    task automatic write_cfg(input int k);
        @(negedge clk);
        cfg_we = 1'b1; cfg_in = 2'(k);
        @(negedge clk);
        cfg_we = 1'b0;
        if (k != mcfg) model_clear();
        mcfg = k;
    endtask

    // runs one frame, checks latency, read traffic and (optionally) the model
    task automatic do_frame(input string req, input longint s [4], input bit use_model,
                            output longint got [4]);
        longint exp [4];
        int n;
        model_frame(s, exp);
        @(negedge clk);
        rd_count = 0; max_sec = -1;
        for (int c = 0; c < 4; c++) sample_in[c*16 +: 16] = 16'(s[c]);
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        n = 1;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " R9 latency"}, n, 24 * mcfg + 1);
        chk({req, " R8 read count"}, rd_count, 20 * mcfg);
        chk({req, " R2 highest section read"}, max_sec, (mcfg == 0) ? -1 : 4 * mcfg - 1);
        for (int c = 0; c < 4; c++) begin
            got[c] = lane(sample_out, c);
            if (use_model) chk({req, " R4 output"}, got[c], exp[c]);
        end
        @(negedge clk);
        chk({req, " R9 done single cycle"}, longint'(done), 0);
    endtask

    localparam int NV = 10;
    localparam int VEC [NV][5] = '{
        '{3,  1000, -2000,  3000, -4000},
        '{3,  5000,  5000, -5000, -5000},
        '{3,     0,     0,     0,     0},
        '{1, 12000, -8000,   300,  -300},
        '{1, 12000, -8000,   300,  -300},
        '{0, -1234,  4321, 32767,-32768},
        '{2, 20000,-20000, 20000,-20000},
        '{2, 20000,-20000, 20000,-20000},
        '{2,    -1,     1,    -7,     7},
        '{3, 32767,-32768, 16384,-16384}
    };

    initial begin
        longint s [4];
        longint got [4];
        int n;
        int dcount;
        model_clear();
        load_general();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done at reset", longint'(done), 0);
        chk("R1 coef_rd at reset", longint'(coef_rd), 0);
        chk("R1 sample_out at reset", longint'(sample_out != 0), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 default code: two sections per channel without any config write
        s = '{longint'(700), longint'(-900), longint'(1100), longint'(-1300)};
        do_frame("R1 default", s, 1'b1, got);

        // table walk: R2 R3 R4 R7
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][0] != mcfg) write_cfg(VEC[v][0]);
            for (int c = 0; c < 4; c++) s[c] = longint'(VEC[v][c+1]);
            do_frame((VEC[v][0] == 0) ? "R3 table" : "R2 R7 table", s, 1'b1, got);
        end

        // R6 passthrough coefficients
        load_pass();
        write_cfg(3);
        s = '{longint'(-32768), longint'(32767), longint'(-5), longint'(12345)};
        do_frame("R6", s, 1'b0, got);
        for (int c = 0; c < 4; c++) chk("R6 identity", got[c], s[c]);

        // R5 saturation both ways (section 0 gain 1.75)
        coef_mem[0][0] = 64'sd1879048192;
        write_cfg(1);
        s = '{longint'(30000), longint'(10), longint'(20), longint'(30)};
        do_frame("R5 high", s, 1'b0, got);
        chk("R5 positive clip", got[0], 32767);
        chk("R5 other lane", got[1], 10);
        s = '{longint'(-30000), longint'(0), longint'(0), longint'(0)};
        do_frame("R5 low", s, 1'b0, got);
        chk("R5 negative clip", got[0], -32768);

        // R7 history clear on code change
        load_general();
        write_cfg(2);
        write_cfg(1);
        s = '{longint'(10000), longint'(10000), longint'(10000), longint'(10000)};
        do_frame("R7 prime", s, 1'b1, got);
        write_cfg(2);
        write_cfg(1);
        s = '{longint'(0), longint'(0), longint'(0), longint'(0)};
        do_frame("R7 cleared", s, 1'b0, got);
        for (int c = 0; c < 4; c++) chk("R7 cleared history gives zero", got[c], 0);

        // R10 strobes during a frame are ignored
        write_cfg(3);
        s = '{longint'(4000), longint'(-4000), longint'(2500), longint'(-2500)};
        begin
            longint exp [4];
            model_frame(s, exp);
            @(negedge clk);
            for (int c = 0; c < 4; c++) sample_in[c*16 +: 16] = 16'(s[c]);
            frame_valid = 1'b1;
            @(negedge clk);
            frame_valid = 1'b0;
            n = 1;
            while (!done && n < 2000) begin
                if (n == 10) begin
                    frame_valid = 1'b1; cfg_we = 1'b1; cfg_in = 2'd1;
                    sample_in = 64'h1111_2222_3333_4444;
                end else begin
                    frame_valid = 1'b0; cfg_we = 1'b0;
                end
                @(negedge clk);
                n++;
            end
            frame_valid = 1'b0; cfg_we = 1'b0;
            chk("R10 latency unchanged", n, 73);
            for (int c = 0; c < 4; c++) chk("R10 output", lane(sample_out, c), exp[c]);
            dcount = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (done) dcount++;
            end
            chk("R10 no second frame", dcount, 0);
        end
        s = '{longint'(1), longint'(2), longint'(3), longint'(4)};
        do_frame("R10 code kept", s, 1'b1, got);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule